// File: doc/BRIEF.md
# Microwire EEPROM Word Reader with Address-Width Discovery

This block is a read-only sequencer for a three-wire serial EEPROM of the 93C46 family organised as 16-bit words. It drives chip select, the serial clock and the serial data line into the memory, and it samples the memory's serial data output. A client asks for one word by pulsing a request with a word address. The block runs the serial read and returns the word together with a single-cycle done pulse.

Parts in this family use different address widths, and no width has to be configured here. The first read after reset shifts the address out most significant bit first with room for up to eight bits. The part drives a dummy low bit once it has received its last address bit, and the block stops shifting as soon as it samples that bit. The number of bits shifted by then is the device's address width. The block then repeats the same read at the width it found, and it keeps that width for every later read.

A sweep request reads every word of the device in ascending order and adds them modulo 2^16. A sound image sums to 0xBABA, and the block raises an error flag for any other total. Each half period of the serial clock lasts a programmable number of system clocks.

Top module: `uwire_rom_reader`

## Requirements
- R1: During reset and right after it, chip select, serial clock, serial data in, busy, done and the width-valid flag are all low.
- R2: Each transaction raises chip select and then shifts the command bits 1, 1, 0 in that order before the address.
- R3: The data line changes only while the serial clock is low. Every high phase and every low phase of the serial clock inside a transaction lasts at least PHASE_CYC system clocks.
- R4: The first operation after reset is a discovery transaction. It shifts rd_addr_i bits from bit MAX_AW-1 downward and samples the memory's output at the end of each clock-high phase. It stops after the first bit whose sample is low. The detected width is the number of address bits shifted, or MAX_AW if no low sample is seen.
- R5: After the address, 16 data bits are clocked in most significant bit first, each sampled at the end of a clock-high phase. The word appears on rd_data_o in the same cycle as a one-cycle done_o pulse.
- R6: Chip select goes low at the end of every transaction and stays low for at least PHASE_CYC system clocks before the next one starts. This includes the gap between discovery and the read that follows it.
- R7: After discovery, the block repeats the read using the detected width w and rd_addr_i[w-1:0]. Every later read shifts exactly w address bits, runs as one transaction, and the width stays unchanged.
- R8: busy_o rises in the cycle after a request is accepted and falls in the same cycle as done_o. Requests that arrive while busy_o is high are ignored.
- R9: A sweep reads addresses 0 to 2^w-1 in ascending order and adds the words modulo 2^16. At the end of the sweep, sum_bad_o is set to (sum != 0xBABA) and done_o pulses with the last word on rd_data_o. sum_bad_o is cleared when a sweep is accepted.
- R10: When sweep_req_i and rd_req_i are high in the same idle cycle, the sweep is performed.
- R11: A sweep issued before the width is known first runs discovery with address 0, then sweeps using the width it found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rd_req_i | input | 1 | Single-word read request, taken when idle |
| rd_addr_i | input | MAX_AW | Word address for a single read |
| sweep_req_i | input | 1 | Whole-device sweep request, taken when idle |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | DATA_W | Last word read |
| aw_o | output | $clog2(MAX_AW+1) | Detected address width |
| aw_valid_o | output | 1 | Width has been discovered |
| sum_bad_o | output | 1 | Last sweep total differed from the image constant |
| ee_cs_o | output | 1 | Memory chip select |
| ee_sk_o | output | 1 | Memory serial clock |
| ee_di_o | output | 1 | Serial data into the memory |
| ee_do_i | input | 1 | Serial data out of the memory |

## Verification
The bench builds the block with PHASE_CYC set to 3 and keeps MAX_AW at 8 and DATA_W at 16. A short phase makes each transaction about 150 cycles long, so several full sweeps fit in one run. A behavioural memory model in the bench can be switched between 4, 6 and 8 address bits across resets. This covers discovery stopping in the middle of the address, stopping only at the last of the eight positions, and a first-operation sweep over a small device.

// File: rtl/uwr_pkg.sv
package uwr_pkg;

    // Serial engine phases.
    typedef enum logic [2:0] {
        E_IDLE = 3'd0,
        E_LOW  = 3'd1,
        E_HIGH = 3'd2,
        E_END  = 3'd3,
        E_GAP  = 3'd4
    } eng_state_e;

    // Field being shifted within a transaction.
    typedef enum logic [1:0] {
        SEG_CMD  = 2'd0,
        SEG_ADDR = 2'd1,
        SEG_DATA = 2'd2
    } seg_e;

    // Sequencer operating mode.
    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_DISC = 2'd1,
        M_READ = 2'd2
    } ctl_mode_e;

    // Start bit and read opcode, sent from bit 2 down to bit 0.
    localparam logic [2:0] READ_SEQ = 3'b110;

endpackage

// File: rtl/uwr_phase_timer.sv
module uwr_phase_timer #(
    parameter int PHASE_CYC = 200
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick_o = (cnt_q == CW'(PHASE_CYC - 1));

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (clr_i || tick_o) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/uwr_serial_engine.sv
module uwr_serial_engine
    import uwr_pkg::*;
#(
    parameter int PHASE_CYC = 200,
    parameter int MAX_AW    = 8,
    parameter int DATA_W    = 16
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         start_i,
    input  logic [MAX_AW-1:0]            addr_i,
    input  logic [$clog2(MAX_AW+1)-1:0]  aw_i,
    input  logic                         detect_i,
    input  logic                         ee_do_i,
    output logic                         ee_cs_o,
    output logic                         ee_sk_o,
    output logic                         ee_di_o,
    output logic                         done_o,
    output logic [DATA_W-1:0]            data_o,
    output logic [$clog2(MAX_AW+1)-1:0]  found_o
);
    localparam int WW = $clog2(MAX_AW + 1);
    localparam int IW = $clog2((DATA_W > MAX_AW) ? DATA_W : MAX_AW);
    localparam int HW = $clog2(PHASE_CYC + 1) + 1;

    typedef struct packed {
        eng_state_e          st;
        seg_e                seg;
        logic [IW-1:0]       idx;
        logic [MAX_AW-1:0]   addr;
        logic [WW-1:0]       aw;
        logic                det;
        logic [DATA_W-1:0]   sh;
        logic [WW-1:0]       found;
        logic                done;
        logic                cs;
        logic                sk;
        logic                di;
    } eng_s;

    eng_s q, n;
    logic tick;
    logic tmr_clr;

    uwr_phase_timer #(
        .PHASE_CYC (PHASE_CYC)
    ) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (tmr_clr),
        .tick_o (tick)
    );

    function automatic logic out_bit(seg_e s, logic [IW-1:0] i, logic [MAX_AW-1:0] a);
        logic [MAX_AW-1:0] av;
        logic [2:0]        cv;
        av = a >> i;
        cv = READ_SEQ >> i;
        case (s)
            SEG_CMD:  return cv[0];
            SEG_ADDR: return av[0];
            default:  return 1'b0;
        endcase
    endfunction

    always_comb begin
        n       = q;
        n.done  = 1'b0;
        tmr_clr = 1'b0;
        case (q.st)
            E_IDLE: begin
                if (start_i) begin
                    n.st    = E_LOW;
                    n.seg   = SEG_CMD;
                    n.idx   = IW'(2);
                    n.addr  = addr_i;
                    n.aw    = aw_i;
                    n.det   = detect_i;
                    tmr_clr = 1'b1;
                end
            end
            E_LOW: begin
                if (tick) n.st = E_HIGH;
            end
            E_HIGH: begin
                if (tick) begin
                    n.st = E_LOW;
                    case (q.seg)
                        SEG_CMD: begin
                            if (q.idx == '0) begin
                                n.seg = SEG_ADDR;
                                n.idx = IW'(q.aw - 1'b1);
                            end else begin
                                n.idx = q.idx - 1'b1;
                            end
                        end
                        SEG_ADDR: begin
                            if ((q.det && !ee_do_i) || (q.idx == '0)) begin
                                n.seg   = SEG_DATA;
                                n.idx   = IW'(DATA_W - 1);
                                n.found = q.aw - WW'(q.idx);
                            end else begin
                                n.idx = q.idx - 1'b1;
                            end
                        end
                        default: begin
                            n.sh = {q.sh[DATA_W-2:0], ee_do_i};
                            if (q.idx == '0) begin
                                n.st = E_END;
                            end else begin
                                n.idx = q.idx - 1'b1;
                            end
                        end
                    endcase
                end
            end
            E_END: begin
                if (tick) n.st = E_GAP;
            end
            E_GAP: begin
                if (tick) begin
                    n.st   = E_IDLE;
                    n.done = 1'b1;
                end
            end
            default: n.st = E_IDLE;
        endcase
        n.cs = (n.st == E_LOW) || (n.st == E_HIGH) || (n.st == E_END);
        n.sk = (n.st == E_HIGH);
        n.di = ((n.st == E_LOW) || (n.st == E_HIGH)) ? out_bit(n.seg, n.idx, n.addr) : 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign ee_cs_o = q.cs;
    assign ee_sk_o = q.sk;
    assign ee_di_o = q.di;
    assign done_o  = q.done;
    assign data_o  = q.sh;
    assign found_o = q.found;

    // Phase-length counters used only by the checks below.
    logic [HW-1:0] hi_len_q, lo_len_q;
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !q.sk) begin
            hi_len_q <= '0;
        end else if (hi_len_q != '1) begin
            hi_len_q <= hi_len_q + 1'b1;
        end
        if (!rst_ni || !q.cs || q.sk) begin
            lo_len_q <= '0;
        end else if (lo_len_q != '1) begin
            lo_len_q <= lo_len_q + 1'b1;
        end
    end

    a_r3_sk_within_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ee_sk_o |-> ee_cs_o);
    a_r3_di_steady_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ee_sk_o && $past(ee_sk_o)) |-> $stable(ee_di_o));
    a_r3_high_phase_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ee_sk_o) |-> (hi_len_q >= HW'(PHASE_CYC)));
    a_r3_low_phase_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ee_sk_o) |-> (lo_len_q >= HW'(PHASE_CYC)));

endmodule

// File: rtl/uwire_rom_reader.sv
module uwire_rom_reader
    import uwr_pkg::*;
#(
    parameter int                PHASE_CYC = 200,
    parameter int                MAX_AW    = 8,
    parameter int                DATA_W    = 16,
    parameter logic [DATA_W-1:0] IMAGE_SUM = 16'hBABA
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         rd_req_i,
    input  logic [MAX_AW-1:0]            rd_addr_i,
    input  logic                         sweep_req_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic [DATA_W-1:0]            rd_data_o,
    output logic [$clog2(MAX_AW+1)-1:0]  aw_o,
    output logic                         aw_valid_o,
    output logic                         sum_bad_o,
    output logic                         ee_cs_o,
    output logic                         ee_sk_o,
    output logic                         ee_di_o,
    input  logic                         ee_do_i
);
    localparam int WW = $clog2(MAX_AW + 1);

    typedef struct packed {
        ctl_mode_e           mode;
        logic                sweep;
        logic [MAX_AW-1:0]   addr;
        logic [WW-1:0]       width;
        logic                wok;
        logic [DATA_W-1:0]   sum;
        logic                err;
        logic [DATA_W-1:0]   data;
        logic                done;
        logic                start;
        logic [WW-1:0]       st_aw;
        logic                st_det;
    } ctl_s;

    ctl_s q, n;

    logic                eng_done;
    logic [DATA_W-1:0]   eng_data;
    logic [WW-1:0]       eng_found;
    logic [MAX_AW-1:0]   last_addr;
    logic [DATA_W-1:0]   sum_next;

    uwr_serial_engine #(
        .PHASE_CYC (PHASE_CYC),
        .MAX_AW    (MAX_AW),
        .DATA_W    (DATA_W)
    ) u_engine (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (q.start),
        .addr_i   (q.addr),
        .aw_i     (q.st_aw),
        .detect_i (q.st_det),
        .ee_do_i  (ee_do_i),
        .ee_cs_o  (ee_cs_o),
        .ee_sk_o  (ee_sk_o),
        .ee_di_o  (ee_di_o),
        .done_o   (eng_done),
        .data_o   (eng_data),
        .found_o  (eng_found)
    );

    assign last_addr = MAX_AW'((32'd1 << q.width) - 32'd1);
    assign sum_next  = q.sum + eng_data;

    always_comb begin
        n       = q;
        n.done  = 1'b0;
        n.start = 1'b0;
        case (q.mode)
            M_IDLE: begin
                if (sweep_req_i || rd_req_i) begin
                    if (sweep_req_i) begin
                        n.sweep = 1'b1;
                        n.addr  = '0;
                        n.sum   = '0;
                        n.err   = 1'b0;
                    end else begin
                        n.sweep = 1'b0;
                        n.addr  = rd_addr_i;
                    end
                    n.start = 1'b1;
                    if (q.wok) begin
                        n.mode   = M_READ;
                        n.st_aw  = q.width;
                        n.st_det = 1'b0;
                    end else begin
                        n.mode   = M_DISC;
                        n.st_aw  = WW'(MAX_AW);
                        n.st_det = 1'b1;
                    end
                end
            end
            M_DISC: begin
                if (eng_done) begin
                    n.width  = eng_found;
                    n.wok    = 1'b1;
                    n.mode   = M_READ;
                    n.start  = 1'b1;
                    n.st_aw  = eng_found;
                    n.st_det = 1'b0;
                end
            end
            M_READ: begin
                if (eng_done) begin
                    n.data = eng_data;
                    if (q.sweep) begin
                        n.sum = sum_next;
                        if (q.addr == last_addr) begin
                            n.err  = (sum_next != IMAGE_SUM);
                            n.done = 1'b1;
                            n.mode = M_IDLE;
                        end else begin
                            n.addr  = q.addr + 1'b1;
                            n.start = 1'b1;
                        end
                    end else begin
                        n.done = 1'b1;
                        n.mode = M_IDLE;
                    end
                end
            end
            default: n.mode = M_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign busy_o     = (q.mode != M_IDLE);
    assign done_o     = q.done;
    assign rd_data_o  = q.data;
    assign aw_o       = q.width;
    assign aw_valid_o = q.wok;
    assign sum_bad_o  = q.err;

    a_r8_busy_falls_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o);
    a_r8_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);
    a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    a_r6_cs_low_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !ee_cs_o);
    a_r4_width_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        aw_valid_o |-> ((aw_o != '0) && (aw_o <= WW'(MAX_AW))));
    a_r7_width_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (aw_valid_o && $past(aw_valid_o)) |-> $stable(aw_o));

endmodule

// File: tb/uwire_rom_reader_tb_top.sv
module uwire_rom_reader_tb_top;
    localparam int PH = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [7:0]  addr = '0;
    logic        sweep = 1'b0;
    logic        busy, done, aw_ok, sum_bad;
    logic [15:0] rdata;
    logic [3:0]  aw;
    logic        ee_cs, ee_sk, ee_di;
    logic        ee_do = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    uwire_rom_reader #(.PHASE_CYC(PH), .MAX_AW(8), .DATA_W(16)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .rd_req_i(req), .rd_addr_i(addr),
        .sweep_req_i(sweep), .busy_o(busy), .done_o(done), .rd_data_o(rdata),
        .aw_o(aw), .aw_valid_o(aw_ok), .sum_bad_o(sum_bad),
        .ee_cs_o(ee_cs), .ee_sk_o(ee_sk), .ee_di_o(ee_di), .ee_do_i(ee_do));

    // Behavioural serial memory.
    logic [15:0] mem [256];
    int model_aw = 6;
    int txn = 0;
    int rec_bits [512];
    int rec_addr [512];
    int rec_cmd  [512];
    int m_cnt = 0, m_addr = 0, m_cmd = 0, m_oidx = 0;
    logic [15:0] m_sh = '0, m_word = '0;
    logic cs_prev_m = 1'b0, sk_prev_m = 1'b0;

    always @(posedge clk) begin
        logic [15:0] nsh;
        cs_prev_m <= ee_cs;
        sk_prev_m <= ee_sk;
        if (!ee_cs) begin
            if (cs_prev_m) begin
                if (txn < 512) begin
                    rec_bits[txn] <= m_cnt;
                    rec_addr[txn] <= m_addr;
                    rec_cmd[txn]  <= m_cmd;
                end
                txn <= txn + 1;
            end
            m_cnt <= 0;
            ee_do <= 1'b1;
            m_sh  <= '0;
        end else if (ee_sk && !sk_prev_m) begin
            m_cnt <= m_cnt + 1;
            if (m_cnt < 3 + model_aw) begin
                nsh = {m_sh[14:0], ee_di};
                m_sh <= nsh;
                if (m_cnt + 1 == 3 + model_aw) begin
                    m_addr <= int'(nsh) & ((1 << model_aw) - 1);
                    m_cmd  <= int'(nsh >> model_aw) & 7;
                    m_word <= mem[int'(nsh) & ((1 << model_aw) - 1)];
                    m_oidx <= 15;
                    ee_do  <= 1'b0;
                end
            end else if (m_oidx >= 0) begin
                ee_do  <= m_word[m_oidx];
                m_oidx <= m_oidx - 1;
            end
        end
    end

    // Pin timing monitor.
    int run = 0, low_run = 1000, phase_viol = 0, di_viol = 0, gap_viol = 0;
    logic sk_p = 1'b0, di_p = 1'b0, cs_p = 1'b0;
    always @(posedge clk) begin
        sk_p <= ee_sk; di_p <= ee_di; cs_p <= ee_cs;
        if (!ee_cs) begin
            run <= 0;
            if (low_run < 1000) low_run <= low_run + 1;
        end else begin
            if (!cs_p && low_run < PH) gap_viol <= gap_viol + 1;
            low_run <= 0;
            if (ee_sk != sk_p) begin
                if (cs_p && run < PH) phase_viol <= phase_viol + 1;
                run <= 1;
            end else begin
                run <= run + 1;
            end
            if (ee_sk && di_p != ee_di) di_viol <= di_viol + 1;
        end
    end

    task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic void fill_image(input int w);
        logic [15:0] s;
        s = '0;
        for (int i = 0; i < (1 << w) - 1; i++) begin
            mem[i] = 16'(i * 16'h1357 + 16'h0F0F);
            s = s + mem[i];
        end
        mem[(1 << w) - 1] = 16'hBABA - s;
    endfunction

    task automatic pulse(input logic sw, input logic rq, input logic [7:0] a);
        @(negedge clk);
        sweep = sw; req = rq; addr = a;
        @(negedge clk);
        sweep = 1'b0; req = 1'b0;
    endtask

    task automatic wait_done(input string rq);
        int k;
        k = 0;
        while (!done && k < 40000) begin
            @(negedge clk);
            k++;
        end
        check(done == 1'b1, rq, "done pulse seen", int'(done), 1);
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check({ee_cs, ee_sk, ee_di, busy, done, aw_ok} == 6'b0, "R1", "outputs in reset",
              int'({ee_cs, ee_sk, ee_di, busy, done, aw_ok}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({ee_cs, ee_sk, ee_di, busy, done, aw_ok} == 6'b0, "R1", "outputs after reset",
              int'({ee_cs, ee_sk, ee_di, busy, done, aw_ok}), 0);
    endtask

    task automatic t_first_read();
        int b;
        b = txn;
        pulse(1'b0, 1'b1, 8'h2D);
        check(busy == 1'b1, "R8", "busy after request", int'(busy), 1);
        wait_done("R5");
        check(busy == 1'b0, "R8", "busy low at done", int'(busy), 0);
        check(rdata == mem[8'h2D], "R5", "first word", int'(rdata), int'(mem[8'h2D]));
        check(aw_ok && aw == 4'd6, "R4", "width found", int'(aw), 6);
        @(negedge clk);
        check(txn - b == 2, "R7", "discovery plus reread", txn - b, 2);
        check(rec_addr[b] == 'h0B, "R4", "discovery address bits", rec_addr[b], 'h0B);
        check(rec_bits[b] == 25, "R4", "discovery stops early", rec_bits[b], 25);
        check(rec_addr[b+1] == 'h2D, "R7", "reread address", rec_addr[b+1], 'h2D);
        check(rec_cmd[b] == 6 && rec_cmd[b+1] == 6, "R2", "command bits", rec_cmd[b+1], 6);
    endtask

    task automatic t_second_read();
        int b;
        b = txn;
        pulse(1'b0, 1'b1, 8'hC7);
        wait_done("R7");
        check(rdata == mem[8'h07], "R7", "low address bits used", int'(rdata), int'(mem[8'h07]));
        @(negedge clk);
        check(txn - b == 1, "R7", "single transaction", txn - b, 1);
        check(rec_bits[b] == 25, "R7", "exact width shifted", rec_bits[b], 25);
        check(aw == 4'd6, "R7", "width unchanged", int'(aw), 6);
    endtask

    task automatic t_busy_ignore();
        int b;
        b = txn;
        pulse(1'b0, 1'b1, 8'h11);
        repeat (10) @(negedge clk);
        pulse(1'b0, 1'b1, 8'h22);
        wait_done("R8");
        check(rdata == mem[8'h11], "R8", "first request served", int'(rdata), int'(mem[8'h11]));
        repeat (30) @(negedge clk);
        check(busy == 1'b0, "R8", "busy request dropped", int'(busy), 0);
        check(txn - b == 1, "R8", "no extra transaction", txn - b, 1);
    endtask

    task automatic t_sweep(input bit both, input bit corrupt, input string rq);
        int b, bad;
        b = txn;
        bad = 0;
        fill_image(6);
        if (corrupt) mem[3] = mem[3] + 16'd1;
        pulse(1'b1, both, 8'h77);
        check(sum_bad == 1'b0, "R9", "flag cleared at sweep start", int'(sum_bad), 0);
        wait_done(rq);
        check(sum_bad == corrupt, rq, "checksum flag", int'(sum_bad), int'(corrupt));
        check(rdata == mem[63], "R9", "last word on data", int'(rdata), int'(mem[63]));
        @(negedge clk);
        check(txn - b == 64, rq, "sweep transaction count", txn - b, 64);
        for (int i = 0; i < 64; i++) if (rec_addr[b+i] != i) bad++;
        check(bad == 0, rq, "ascending addresses", bad, 0);
    endtask

    task automatic t_width8();
        int b;
        do_reset();
        model_aw = 8;
        fill_image(8);
        b = txn;
        pulse(1'b0, 1'b1, 8'hA5);
        wait_done("R4");
        check(aw_ok && aw == 4'd8, "R4", "full width found", int'(aw), 8);
        check(rdata == mem[8'hA5], "R4", "word at full width", int'(rdata), int'(mem[8'hA5]));
        @(negedge clk);
        check(txn - b == 2 && rec_addr[b] == 'hA5 && rec_bits[b] == 27, "R4",
              "discovery over all positions", rec_bits[b], 27);
    endtask

    task automatic t_first_sweep4();
        int b;
        do_reset();
        model_aw = 4;
        fill_image(4);
        b = txn;
        pulse(1'b1, 1'b0, 8'h00);
        wait_done("R11");
        check(aw == 4'd4, "R11", "width from sweep", int'(aw), 4);
        check(sum_bad == 1'b0, "R11", "good small image", int'(sum_bad), 0);
        @(negedge clk);
        check(txn - b == 17, "R11", "discovery then sweep", txn - b, 17);
        check(rec_addr[b] == 0 && rec_bits[b] == 23, "R11", "discovery at address 0", rec_bits[b], 23);
        check(rec_addr[b+16] == 15, "R11", "last swept address", rec_addr[b+16], 15);
    endtask

    initial begin
        fill_image(6);
        t_reset_state();
        t_first_read();
        t_second_read();
        t_busy_ignore();
        t_sweep(1'b0, 1'b0, "R9");
        t_sweep(1'b0, 1'b1, "R9");
        t_sweep(1'b1, 1'b0, "R10");
        t_width8();
        t_first_sweep4();
        check(phase_viol == 0, "R3", "clock phase length", phase_viol, 0);
        check(di_viol == 0, "R3", "data change while clock high", di_viol, 0);
        check(gap_viol == 0, "R6", "chip select low gap", gap_viol, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule